// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block decides, at each instruction boundary of an 8-bit CPU core, whether an interrupt is taken, which source wins, and at which address its service routine starts. It has five request pins, listed from highest to lowest priority:

- a non-maskable trap;
- three vectored levels named 7.5, 6.5 and 5.5, each with its own mask bit;
- a general request that carries no internal vector.

Every pin passes through a synchronizer. The pins differ in how a request is seen:

- The trap is accepted only when a captured rising edge coincides with a pin that is still high.
- Level 7.5 is caught by a sticky edge latch.
- Levels 6.5 and 5.5 and the general request are plain levels.

The core supplies four pulses:

- `bound_i` is a one-cycle strobe at each instruction boundary.
- `ei_i` and `di_i` mark an executed enable or disable instruction.
- `cfg_we_i` writes a mask/serial-output byte.

The block always presents a status byte. The core decodes instructions and runs the bus sequence that vectors the CPU. The recognized source and its vector appear on `take_o`, `src_o` and `vec_o` for one cycle after the strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: On a taken interrupt exactly one bit of `src_o` is set. The source bits are: bit 4 trap, bit 3 level 7.5, bit 2 level 6.5, bit 1 level 5.5, bit 0 general request. When several sources qualify, the fixed order trap > 7.5 > 6.5 > 5.5 > general decides.
- R2: `vec_o` is 0x0024 for trap, 0x003C for 7.5, 0x0034 for 6.5, 0x002C for 5.5, and 0x0000 for the general request.
- R3: The trap ignores the enable flag and the masks. It is taken only if a rising edge was captured and the pin is still high at the strobe. After it is taken, a pin that stays high does not cause it to be taken again.
- R4: A rising edge on level 7.5 sets a latch, which stays set after the pin falls. The latch is cleared when 7.5 is taken, or when a configuration write has bit 4 = 1.
- R5: Levels 6.5, 5.5 and the general request are taken only while the pin is high at the strobe and the enable flag is active. Levels 6.5 and 5.5 must also be unmasked.
- R6: After `ei_i`, maskable sources are not honored at the next strobe, which ends the enable instruction. They are honored from the strobe after that.
- R7: `di_i` clears the enable flag, and so does taking any interrupt, including the trap.
- R8: A configuration write loads bits [2:0] as the masks for 5.5/6.5/7.5 (1 = masked), but only when bit 3 = 1. Bit 5 has no effect.
- R9: `ser_out_o` takes configuration bit 7 only when bit 6 = 1. Otherwise it keeps its value.
- R10: The layout of `stat_o` is: [2:0] the masks for 5.5/6.5/7.5; [3] the enable flag; [4] pin 5.5 high; [5] pin 6.5 high; [6] the 7.5 latch; [7] the synchronized serial input. Bits [6:4] ignore the masks and the enable flag.
- R11: After reset the masks read 111, the enable flag is 0, `ser_out_o` is 0, and nothing is taken.
- R12: `take_o` rises only in the cycle after a strobe, and only if some source qualified at that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_trap_i | input | 1 | Non-maskable trap pin |
| irq_l75_i | input | 1 | Level 7.5 request (edge) |
| irq_l65_i | input | 1 | Level 6.5 request (level) |
| irq_l55_i | input | 1 | Level 5.5 request (level) |
| irq_gen_i | input | 1 | General non-vectored request |
| ser_in_i | input | 1 | Serial input pin |
| bound_i | input | 1 | Instruction-boundary sample strobe |
| ei_i | input | 1 | Enable instruction executed |
| di_i | input | 1 | Disable instruction executed |
| cfg_we_i | input | 1 | Configuration byte write |
| cfg_wdata_i | input | 8 | Configuration byte |
| stat_o | output | 8 | Status byte |
| ser_out_o | output | 1 | Serial output latch |
| take_o | output | 1 | Interrupt taken |
| src_o | output | 5 | One-hot winning source |
| vec_o | output | 16 | Service vector address |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a strobe in which several sources qualify at once while the enable flag clears. The bench holds several pins high together, some masked and some not, and compares the single winner and its vector with a priority chain of its own. The second pair is a 7.5 latch clear by configuration write that competes with recognition. The bench issues that write between pin changes and strobes, then judges the cleared latch through `stat_o` bit 6 and the absence of a later 7.5 grant. Random pin patterns, mask writes and enable/disable pulses drawn from a fixed seed are mixed with directed sequences for the enable delay and the trap's re-trigger.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned SRC_N = 5;
  localparam int unsigned VEC_W = 16;

  // one-hot index of each source
  localparam int unsigned IX_GEN  = 0;
  localparam int unsigned IX_L55  = 1;
  localparam int unsigned IX_L65  = 2;
  localparam int unsigned IX_L75  = 3;
  localparam int unsigned IX_TRAP = 4;

  // highest set index wins
  function automatic logic [SRC_N-1:0] pick_top(input logic [SRC_N-1:0] req);
    logic [SRC_N-1:0] g;
    logic             found;
    g     = '0;
    found = 1'b0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (req[i] && !found) begin
        g[i]  = 1'b1;
        found = 1'b1;
      end
    end
    return g;
  endfunction

  // vector = 8 * level + 4; trap sits at level 4, vectored levels at index + 4
  function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_N-1:0] g);
    logic [VEC_W-1:0] v;
    v = '0;
    for (int i = 1; i < SRC_N; i++) begin
      if (g[i]) begin
        if (i == IX_TRAP) v = VEC_W'(4 * 8 + 4);
        else              v = VEC_W'((i + 4) * 8 + 4);
      end
    end
    return v;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_edge_cap.sv
module irq_edge_cap (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic clr,
  output logic flag,
  output logic rise
);
  logic prev_q;

  assign rise = lvl & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (rise)     flag <= 1'b1;  // a fresh edge wins over a clear
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_ctl_pkg::*;
(
  input  logic [SRC_N-1:0] req,
  output logic [SRC_N-1:0] grant,
  output logic [VEC_W-1:0] vec
);
  assign grant = pick_top(req);
  assign vec   = vec_of(grant);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_trap_i,
  input  logic             irq_l75_i,
  input  logic             irq_l65_i,
  input  logic             irq_l55_i,
  input  logic             irq_gen_i,
  input  logic             ser_in_i,
  input  logic             bound_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_wdata_i,
  output logic [7:0]       stat_o,
  output logic             ser_out_o,
  output logic             take_o,
  output logic [SRC_N-1:0] src_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int unsigned PIN_N = SRC_N + 1;

  logic [PIN_N-1:0] pin_s;
  logic trap_s, l75_s, l65_s, l55_s, gen_s, sid_s;

  irq_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .d   ({ser_in_i, irq_trap_i, irq_l75_i, irq_l65_i, irq_l55_i, irq_gen_i}),
    .q   (pin_s)
  );
  assign {sid_s, trap_s, l75_s, l65_s, l55_s, gen_s} = pin_s;

  // named internal events
  logic             ie_q, hold_q, ie_ok;
  logic [2:0]       mask_q;
  logic             sod_q;
  logic             trap_flag, trap_rise, l75_flag, l75_rise;
  logic [SRC_N-1:0] req, grant;
  logic [VEC_W-1:0] vec_n;
  logic             recog, clr_trap, clr_l75, mask_wr, sod_wr;
  logic             unused_bit5;

  assign unused_bit5 = cfg_wdata_i[5];
  assign ie_ok    = ie_q & ~hold_q;
  assign recog    = bound_i & (|grant);
  assign clr_trap = recog & grant[IX_TRAP];
  assign clr_l75  = (recog & grant[IX_L75]) | (cfg_we_i & cfg_wdata_i[4]);
  assign mask_wr  = cfg_we_i & cfg_wdata_i[3];
  assign sod_wr   = cfg_we_i & cfg_wdata_i[6];

  irq_edge_cap u_trap_cap (
    .clk (clk), .rst_n (rst_n), .lvl (trap_s), .clr (clr_trap),
    .flag (trap_flag), .rise (trap_rise)
  );

  irq_edge_cap u_l75_cap (
    .clk (clk), .rst_n (rst_n), .lvl (l75_s), .clr (clr_l75),
    .flag (l75_flag), .rise (l75_rise)
  );

  always_comb begin
    req          = '0;
    req[IX_TRAP] = trap_flag & trap_s;
    req[IX_L75]  = l75_flag & ~mask_q[2] & ie_ok;
    req[IX_L65]  = l65_s    & ~mask_q[1] & ie_ok;
    req[IX_L55]  = l55_s    & ~mask_q[0] & ie_ok;
    req[IX_GEN]  = gen_s    & ie_ok;
  end

  irq_pick u_pick (.req (req), .grant (grant), .vec (vec_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      hold_q <= 1'b0;
      mask_q <= 3'b111;
      sod_q  <= 1'b0;
      take_o <= 1'b0;
      src_o  <= '0;
      vec_o  <= '0;
    end else begin
      if (recog || di_i) ie_q <= 1'b0;
      else if (ei_i)     ie_q <= 1'b1;

      if (ei_i)         hold_q <= ~bound_i;
      else if (bound_i) hold_q <= 1'b0;

      if (mask_wr) mask_q <= cfg_wdata_i[2:0];
      if (sod_wr)  sod_q  <= cfg_wdata_i[7];

      take_o <= recog;
      src_o  <= bound_i ? grant : '0;
      vec_o  <= bound_i ? vec_n : '0;
    end
  end

  assign ser_out_o = sod_q;
  assign stat_o    = {sid_s, l75_flag, l65_s, l55_s, ie_q, mask_q};
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bound_i,
  input logic        take_o,
  input logic [4:0]  src_o,
  input logic [15:0] vec_o,
  input logic        ie_q,
  input logic        ie_ok,
  input logic [2:0]  mask_q,
  input logic        trap_flag,
  input logic        trap_s
);
  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $countones(src_o) == 1);

  a_r12_take_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(bound_i));

  a_r7_enable_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !ie_q);

  a_r5_l65_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o[2]) |-> $past(!mask_q[1] && ie_ok));

  a_r3_trap_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o[4]) |-> $past(trap_flag && trap_s));

  a_r2_trap_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o[4]) |-> vec_o == 16'h0024);
endmodule

bind prio_irq_ctrl irq_ctl_chk u_chk (
  .clk (clk), .rst_n (rst_n), .bound_i (bound_i), .take_o (take_o),
  .src_o (src_o), .vec_o (vec_o), .ie_q (ie_q), .ie_ok (ie_ok),
  .mask_q (mask_q), .trap_flag (trap_flag), .trap_s (trap_s)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap = 0, l75 = 0, l65 = 0, l55 = 0, gen = 0, sid = 0;
  logic bound = 0, ei = 0, di = 0, we = 0;
  logic [7:0]  wdata = '0;
  logic [7:0]  stat;
  logic        sod, take;
  logic [4:0]  src;
  logic [15:0] vec;

  int checks = 0, fails = 0;

  // bench model state
  logic m_ie = 0, m_hold = 0, m_sod = 0, m_ltrap = 0, m_l75 = 0;
  logic [2:0] m_mask = 3'b111;

  always #2 clk = ~clk;

  prio_irq_ctrl uut (
    .clk (clk), .rst_n (rst_n), .irq_trap_i (trap), .irq_l75_i (l75),
    .irq_l65_i (l65), .irq_l55_i (l55), .irq_gen_i (gen), .ser_in_i (sid),
    .bound_i (bound), .ei_i (ei), .di_i (di), .cfg_we_i (we),
    .cfg_wdata_i (wdata), .stat_o (stat), .ser_out_o (sod), .take_o (take),
    .src_o (src), .vec_o (vec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input logic [4:0] s);
    case (s)
      5'b10000: return 16'h0024;
      5'b01000: return 16'h003C;
      5'b00100: return 16'h0034;
      5'b00010: return 16'h002C;
      default:  return 16'h0000;
    endcase
  endfunction

  function automatic logic [7:0] exp_stat();
    return {sid, m_l75, l65, l55, m_ie, m_mask};
  endfunction

  task automatic set_pins(input logic t, input logic a, input logic b,
                          input logic c, input logic g, input logic s);
    if (!trap && t) m_ltrap = 1'b1;
    if (!l75 && a)  m_l75   = 1'b1;
    trap = t; l75 = a; l65 = b; l55 = c; gen = g; sid = s;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_ei();
    ei = 1'b1; @(negedge clk); ei = 1'b0;
    m_ie = 1'b1; m_hold = 1'b1;
  endtask

  task automatic pulse_di();
    di = 1'b1; @(negedge clk); di = 1'b0;
    m_ie = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] d);
    we = 1'b1; wdata = d; @(negedge clk); we = 1'b0;
    if (d[4]) m_l75  = 1'b0;
    if (d[3]) m_mask = d[2:0];
    if (d[6]) m_sod  = d[7];
  endtask

  // strobe one boundary and compare the grant with the model
  task automatic strobe(input string tag);
    logic ok;
    logic [4:0] e;
    ok = m_ie & ~m_hold;
    e  = '0;
    if (m_ltrap && trap)                e = 5'b10000;
    else if (m_l75 && !m_mask[2] && ok) e = 5'b01000;
    else if (l65 && !m_mask[1] && ok)   e = 5'b00100;
    else if (l55 && !m_mask[0] && ok)   e = 5'b00010;
    else if (gen && ok)                 e = 5'b00001;
    bound = 1'b1; @(negedge clk); bound = 1'b0;
    m_hold = 1'b0;
    if (e != 0) begin
      m_ie = 1'b0;
      if (e[4]) m_ltrap = 1'b0;
      if (e[3]) m_l75   = 1'b0;
    end
    check({tag, " R12 take"}, 32'(take), 32'(e != 0));
    check({tag, " R1 src"}, 32'(src), 32'(e));
    check({tag, " R2 vec"}, 32'(vec), 32'(exp_vec(e)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 stat", 32'(stat), 32'h07);
    check("R11 sod", 32'(sod), 32'h0);
    check("R11 take", 32'(take), 32'h0);

    // R5 level with enable off: nothing taken
    set_pins(0, 0, 0, 1, 0, 0);
    strobe("R5 disabled");
    // R8 unmask only with bit3, R6 delay after enable
    cfg_write(8'h20);            // bit5 only: no effect (R8)
    check("R8 bit5 ignored", 32'(stat[2:0]), 32'h7);
    cfg_write(8'h00);            // bit3 clear: mask unchanged
    check("R8 no enable bit", 32'(stat[2:0]), 32'h7);
    cfg_write(8'h08);
    check("R8 masks loaded", 32'(stat[2:0]), 32'h0);
    pulse_ei();
    strobe("R6 first boundary blocked");
    check("R6 still blocked", 32'(take), 32'h0);
    strobe("R6 second boundary 5.5");
    check("R7 enable cleared after take", 32'(stat[3]), 32'h0);

    // R1 priority with several levels and the general request
    set_pins(0, 1, 1, 1, 1, 1);
    check("R10 stat pending", 32'(stat), 32'(exp_stat()));
    pulse_ei(); strobe("R6 gap");
    strobe("R1 7.5 wins");
    pulse_ei(); strobe("R6 gap");
    strobe("R1 6.5 next");
    cfg_write(8'h0A);            // mask 6.5
    pulse_ei(); strobe("R6 gap");
    strobe("R5 6.5 masked -> 5.5");
    pulse_ei(); pulse_di();
    strobe("R7 disable blocks");

    // R4 latch persists after pin falls, cleared by write bit4
    set_pins(0, 0, 0, 0, 0, 0);
    set_pins(0, 1, 0, 0, 0, 0);
    set_pins(0, 0, 0, 0, 0, 0);
    check("R4 latch held", 32'(stat[6]), 32'h1);
    cfg_write(8'h10);
    check("R4 latch cleared", 32'(stat[6]), 32'h0);
    pulse_ei(); strobe("R6 gap");
    strobe("R4 no grant after clear");

    // R3 trap ignores disable, no re-trigger while held
    pulse_di();
    set_pins(1, 0, 0, 0, 0, 0);
    strobe("R3 trap taken");
    strobe("R3 trap held no retrigger");
    set_pins(0, 0, 0, 0, 0, 0);
    set_pins(1, 0, 0, 0, 0, 0);
    strobe("R3 trap again after new edge");

    // R9 serial output
    cfg_write(8'h80);
    check("R9 no enable keeps sod", 32'(sod), 32'h0);
    cfg_write(8'hC0);
    check("R9 sod set", 32'(sod), 32'h1);
    cfg_write(8'h40);
    check("R9 sod cleared", 32'(sod), 32'h0);

    // constrained random
    for (int it = 0; it < 300; it++) begin
      logic [5:0] p;
      int unsigned op;
      p = 6'($urandom);
      set_pins(p[5] & p[4], p[4], p[3], p[2], p[1], p[0]);
      op = $urandom % 8;
      if (op == 0) pulse_ei();
      else if (op == 1) pulse_di();
      else if (op < 4) cfg_write(8'($urandom) | 8'h08);
      check("R10 stat random", 32'(stat), 32'(exp_stat()));
      check("R9 sod random", 32'(sod), 32'(m_sod));
      strobe("R1 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule